// File: doc/BRIEF.md
# Half-Rate Shift-Add FIR Decimator

This block sits after an integrator-comb decimator in a sigma-delta receive chain. It halves the sample rate and applies an 11-tap linear-phase low-pass response. Signed samples arrive with a valid strobe, and in-valid can drop low between any two samples. Every second accepted sample produces one 24-bit output word, marked by a single-cycle output strobe.

The block has no hardware multipliers. Incoming samples are sorted by parity into two delay lines, one per polyphase branch, so all arithmetic runs once per output. The two taps of each mirrored pair are added before weighting, which leaves six weighted terms. Each weight is built from at most three signed power-of-two terms. The full-precision sum is scaled down by 2^10 with round-half-up and clamped to the 24-bit range.

Top module: `dec2_csd_fir`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid is 0 and out_data is 0.
- R2: Accepted samples are numbered from 0 after reset. Even numbers feed the even branch and odd numbers feed the odd branch. One output is produced for each odd-numbered sample, so N accepted samples give floor(N/2) outputs.
- R3: The clock edge that accepts an odd-numbered sample is followed by out_valid high for exactly one cycle, two edges later. out_data keeps its value in every cycle where out_valid is low.
- R4: Cycles with in_valid low are ignored. The output sequence and its values depend only on the accepted samples, not on the gaps between them.
- R5: For odd sample number n, the output is built from acc = sum over k=0..10 of h[k]*x[n-k]. Samples before number 0 count as zero.
- R6: The weights h[0..10] are -8, -24, 16, 96, 224, 416, 224, 96, 16, -24, -8, all scaled by 2^-10. They are mirror-symmetric (h[k]=h[10-k]), and each one is realised as shifts and adds.
- R7: The output is floor((acc+512)/1024), which rounds an exact half upward.
- R8: A rounded result above 2^23-1 becomes 2^23-1. A rounded result below -2^23 becomes -2^23.
- R9: An impulse at even sample number n0 reaches its largest output, 416/1024 of its height, at the output for sample n0+5. This is the 5-sample group delay.
- R10: A constant input held long enough to fill the window gives that same constant at the output (unity DC gain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W (24) | Signed input sample |
| out_valid | output | 1 | Output sample strobe, one cycle wide |
| out_data | output | OUT_W (24) | Signed rounded and clamped output |

## Verification
The bench sends an impulse to locate the group delay. A design that paired the wrong branch taps, or swapped the sample parity, would put the 416 peak at the wrong output, or at the odd-weight positions. Inputs chosen so that the sum lands exactly on a half step check the rounding: truncation or symmetric rounding would give 6 instead of 7 for +16, or -7 for -16. Full-scale patterns whose signs follow the weights drive both clamp limits, where a design that wrapped would show a sign flip. Random gaps in in_valid expose any state that moves on idle cycles.

// File: rtl/dec2_fir_pkg.sv
package dec2_fir_pkg;

  localparam int NTAP  = 11;
  localparam int HALF  = (NTAP - 1) / 2;
  localparam int NDIG  = 3;
  localparam int CFRAC = 10;

  typedef struct packed {
    logic       en;
    logic       neg;
    logic [3:0] sh;
  } csd_digit_t;

  function automatic int fold(input int k);
    return (k > HALF) ? (NTAP - 1 - k) : k;
  endfunction

  function automatic csd_digit_t mk(input logic neg, input int sh);
    csd_digit_t r;
    r.en  = 1'b1;
    r.neg = neg;
    r.sh  = 4'(sh);
    return r;
  endfunction

  // Signed-digit recipe for each weight; digit d of tap k.
  function automatic csd_digit_t csd_digit(input int k, input int d);
    csd_digit_t r;
    r = '0;
    case (fold(k))
      0: if (d == 0) r = mk(1'b1, 3);
      1: begin
           if (d == 0) r = mk(1'b1, 5);
           if (d == 1) r = mk(1'b0, 3);
         end
      2: if (d == 0) r = mk(1'b0, 4);
      3: begin
           if (d == 0) r = mk(1'b0, 6);
           if (d == 1) r = mk(1'b0, 5);
         end
      4: begin
           if (d == 0) r = mk(1'b0, 8);
           if (d == 1) r = mk(1'b1, 5);
         end
      5: begin
           if (d == 0) r = mk(1'b0, 9);
           if (d == 1) r = mk(1'b1, 6);
           if (d == 2) r = mk(1'b1, 5);
         end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Plain integer weights, kept apart from the digit recipe for checking.
  function automatic int coef_value(input int k);
    case (fold(k))
      0: return -8;
      1: return -24;
      2: return 16;
      3: return 96;
      4: return 224;
      5: return 416;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/dec2_phase_line.sv
module dec2_phase_line #(
  parameter int W     = 24,
  parameter int DEPTH = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] taps [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)        taps[i] <= '0;
        else if (shift_en) taps[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)        taps[i] <= '0;
        else if (shift_en) taps[i] <= taps[i-1];
      end
    end
  end

endmodule

// File: rtl/dec2_csd_mac.sv
module dec2_csd_mac #(
  parameter int AW    = 25,
  parameter int ACC_W = 38,
  parameter int TAP   = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [AW-1:0]    a,
  output logic signed [ACC_W-1:0] product
);
  import dec2_fir_pkg::*;

  localparam logic signed [ACC_W-1:0] COEF_V = ACC_W'(coef_value(TAP));

  logic signed [ACC_W-1:0] a_ext;
  logic signed [ACC_W-1:0] term [NDIG];

  assign a_ext = {{(ACC_W-AW){a[AW-1]}}, a};

  for (genvar d = 0; d < NDIG; d++) begin : g_digit
    localparam csd_digit_t DG = csd_digit(TAP, d);
    if (DG.en) begin : g_on
      if (DG.neg) begin : g_sub
        assign term[d] = -(a_ext <<< DG.sh);
      end else begin : g_add
        assign term[d] = a_ext <<< DG.sh;
      end
    end else begin : g_off
      assign term[d] = '0;
    end
  end

  always_comb begin
    product = '0;
    for (int d = 0; d < NDIG; d++) product = product + term[d];
  end

  AST_CSD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    product == a_ext * COEF_V); // R6

endmodule

// File: rtl/dec2_round_sat.sv
module dec2_round_sat #(
  parameter int ACC_W = 38,
  parameter int OUT_W = 24,
  parameter int FRAC  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [OUT_W-1:0] y,
  output logic                    sat_hit
);

  localparam int XW = ACC_W + 1;
  localparam logic signed [XW-1:0] HALF_LSB = XW'(1) <<< (FRAC - 1);
  localparam logic signed [XW-1:0] Y_MAX = (XW'(1) <<< (OUT_W - 1)) - XW'(1);
  localparam logic signed [XW-1:0] Y_MIN = -(XW'(1) <<< (OUT_W - 1));

  function automatic logic signed [XW-1:0] round_up(input logic signed [ACC_W-1:0] v);
    logic signed [XW-1:0] w;
    w = {v[ACC_W-1], v};
    return (w + HALF_LSB) >>> FRAC;
  endfunction

  logic signed [XW-1:0] rnd;

  always_comb begin
    rnd     = round_up(acc);
    sat_hit = 1'b0;
    y       = rnd[OUT_W-1:0];
    if (rnd > Y_MAX) begin
      y       = Y_MAX[OUT_W-1:0];
      sat_hit = 1'b1;
    end else if (rnd < Y_MIN) begin
      y       = Y_MIN[OUT_W-1:0];
      sat_hit = 1'b1;
    end
  end

  logic signed [XW+1:0] resid;
  assign resid = {{3{acc[ACC_W-1]}}, acc} - ({{(XW+2-OUT_W){y[OUT_W-1]}}, y} <<< FRAC);

  AST_ROUND_HALF_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_hit |-> (resid >= -(XW+2)'(HALF_LSB) && resid < (XW+2)'(HALF_LSB))); // R7
  AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |-> (y == Y_MAX[OUT_W-1:0] || y == Y_MIN[OUT_W-1:0])); // R8

endmodule

// File: rtl/dec2_csd_fir.sv
module dec2_csd_fir #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  import dec2_fir_pkg::*;

  localparam int EV_DEPTH = (NTAP - 1) / 2;
  localparam int OD_DEPTH = (NTAP + 1) / 2;
  localparam int PW       = IN_W + 1;
  localparam int ACC_W    = IN_W + 14;

  logic                    phase_odd;
  logic                    take_even;
  logic                    take_odd;
  logic                    fire;
  logic signed [IN_W-1:0]  ev_taps [EV_DEPTH];
  logic signed [IN_W-1:0]  od_taps [OD_DEPTH];
  logic signed [PW-1:0]    pre     [HALF+1];
  logic signed [ACC_W-1:0] prod    [HALF+1];
  logic signed [ACC_W-1:0] acc;
  logic signed [OUT_W-1:0] y_next;
  logic                    sat_hit;

  assign take_even = in_valid && !phase_odd;
  assign take_odd  = in_valid &&  phase_odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_odd <= 1'b0;
      fire      <= 1'b0;
    end else begin
      if (in_valid) phase_odd <= !phase_odd;
      fire <= take_odd;
    end
  end

  dec2_phase_line #(.W(IN_W), .DEPTH(EV_DEPTH)) u_even_line (
    .clk(clk), .rst_n(rst_n), .shift_en(take_even), .din(in_data), .taps(ev_taps)
  );

  dec2_phase_line #(.W(IN_W), .DEPTH(OD_DEPTH)) u_odd_line (
    .clk(clk), .rst_n(rst_n), .shift_en(take_odd), .din(in_data), .taps(od_taps)
  );

  // Mirror folding: even weights pair odd-branch taps, odd weights pair
  // even-branch taps, and the centre weight sees one even-branch tap.
  for (genvar k = 0; k <= HALF; k++) begin : g_fold
    if (k % 2 == 0) begin : g_odd_pair
      assign pre[k] = PW'(od_taps[k/2]) + PW'(od_taps[OD_DEPTH-1-k/2]);
    end else if (k == HALF) begin : g_centre
      assign pre[k] = PW'(ev_taps[(k-1)/2]);
    end else begin : g_even_pair
      assign pre[k] = PW'(ev_taps[(k-1)/2]) + PW'(ev_taps[EV_DEPTH-1-(k-1)/2]);
    end

    dec2_csd_mac #(.AW(PW), .ACC_W(ACC_W), .TAP(k)) u_mac (
      .clk(clk), .rst_n(rst_n), .a(pre[k]), .product(prod[k])
    );
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k <= HALF; k++) acc = acc + prod[k];
  end

  dec2_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .FRAC(CFRAC)) u_round (
    .clk(clk), .rst_n(rst_n), .acc(acc), .y(y_next), .sat_hit(sat_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= y_next;
    end
  end

  AST_OUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R3
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2)); // R3

endmodule

// File: tb/dec2_csd_fir_bench.sv
module dec2_csd_fir_bench;
  localparam int IN_W  = 24;
  localparam int OUT_W = 24;
  localparam longint SMAX = (64'sd1 <<< 23) - 1;
  localparam longint SMIN = -(64'sd1 <<< 23);

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic signed [IN_W-1:0]  in_data = '0;
  logic                    out_valid;
  logic signed [OUT_W-1:0] out_data;

  dec2_csd_fir #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dec2_csd_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  typedef struct { longint due; longint val; } exp_t;

  int     h [11] = '{-8, -24, 16, 96, 224, 416, 224, 96, 16, -24, -8};
  longint hist [$];
  exp_t   pend [$];
  longint seen [$];
  longint cyc = 0;
  int     vec = 0;
  int     bad = 0;
  int     n_out = 0;
  bit     done = 0;
  string  req = "R1";

  always @(posedge clk) cyc++;

  function automatic longint ref_out();
    longint a = 0;
    longint r;
    int n = hist.size() - 1;
    for (int k = 0; k < 11; k++)
      if (n - k >= 0) a += longint'(h[k]) * hist[n-k];
    r = (a + 512) >>> 10;
    if (r > SMAX) r = SMAX;
    if (r < SMIN) r = SMIN;
    return r;
  endfunction

  task automatic check(string r, longint act, longint exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic tick(bit v, longint d);
    bit expv;
    @(negedge clk);
    expv = (pend.size() > 0) && (pend[0].due == cyc);
    vec++;
    if (out_valid !== expv) begin
      bad++;
      $display("FAIL %s: out_valid actual %0d expected %0d at cycle %0d", req, out_valid, expv, cyc);
    end else if (expv) begin
      n_out++;
      seen.push_back(longint'(out_data));
      if (longint'(out_data) != pend[0].val) begin
        bad++;
        $display("FAIL %s: out_data actual %0d expected %0d", req, out_data, pend[0].val);
      end
    end
    if (expv) void'(pend.pop_front());
    in_valid = v;
    in_data  = d[IN_W-1:0];
    if (v) begin
      hist.push_back(d);
      if (hist.size() % 2 == 0) pend.push_back('{cyc + 2, ref_out()});
    end
  endtask

  task automatic send(longint d, int gap);
    tick(1'b1, d);
    repeat (gap) tick(1'b0, 0);
  endtask

  task automatic flush();
    if (hist.size() % 2 == 1) send(0, 0);
    repeat (12) send(0, 0);
    repeat (4) tick(1'b0, 0);
    seen.delete();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    check("R1 reset valid", longint'(out_valid), 0);
    check("R1 reset data", longint'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset valid", longint'(out_valid), 0);
    check("R1 after reset data", longint'(out_data), 0);

    // R9 and R6: impulse at an even sample number
    req = "R9";
    flush();
    send(1024, 0);
    repeat (11) send(0, 0);
    repeat (4) tick(1'b0, 0);
    check("R6 first odd weight", seen[0], -24);
    check("R6 second odd weight", seen[1], 96);
    check("R9 peak at n0+5", seen[2], 416);
    check("R6 mirrored weight", seen[3], 96);

    // R10 and R3: back-to-back constant stream
    req = "R3";
    flush();
    repeat (24) send(1000, 0);
    repeat (4) tick(1'b0, 0);
    check("R10 DC gain", seen[seen.size()-1], 1000);

    // R4 and R5: random values with random idle gaps
    req = "R4";
    for (int i = 0; i < 80; i++)
      send(longint'($signed($urandom)) >>> 11, int'($urandom % 3));
    req = "R5";
    for (int i = 0; i < 40; i++)
      send(longint'($signed($urandom)) >>> 9, 0);
    repeat (4) tick(1'b0, 0);

    // R7: exact half steps
    req = "R7";
    flush();
    send(16, 0);
    repeat (11) send(0, 0);
    repeat (4) tick(1'b0, 0);
    check("R7 +half rounds up", seen[2], 7);
    flush();
    send(-16, 1);
    repeat (11) send(0, 0);
    repeat (4) tick(1'b0, 0);
    check("R7 -half rounds up", seen[2], -6);

    // R8: full-scale patterns whose signs follow the weights
    req = "R8";
    flush();
    send(0, 0);
    for (int k = 10; k >= 0; k--) send((h[k] < 0) ? SMIN : SMAX, 0);
    repeat (4) tick(1'b0, 0);
    check("R8 clamp high", seen[seen.size()-1], SMAX);
    flush();
    send(0, 0);
    for (int k = 10; k >= 0; k--) send((h[k] < 0) ? SMAX : SMIN, 0);
    repeat (4) tick(1'b0, 0);
    check("R8 clamp low", seen[seen.size()-1], SMIN);

    req = "R2";
    if (hist.size() % 2 == 1) send(7, 0);
    send(5, 0);
    repeat (6) tick(1'b0, 0);
    check("R2 output count", longint'(n_out), longint'(hist.size() / 2));
    check("R2 nothing pending", longint'(pend.size()), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule